// File: doc/BRIEF.md
# System Clock Ratio Generator

This block turns one source tick stream into three related clock-enable streams: a core enable, a bus enable and a peripheral enable. All of them are single-cycle strobes in the block's own clock domain. Two source tick inputs are offered, one from the crystal and one from the PLL. A bypass field in the configuration word picks which of them drives the dividers.

The ratios come from fixed lookup tables that are indexed by small code fields of a 28-bit configuration word. The bus table is not uniform and includes divide-by-5 and divide-by-6. The peripheral enable is a further division of the bus enable and is not taken from the source.

A newly loaded word waits in a shadow register. It becomes active only at the first source tick where all three dividers finish their periods together, so a reconfiguration never cuts a period short.

The active word is read back unchanged, together with its decoded divisors, the selected source and the PLL multiplier terms. These terms are the feedback product, the input divisor and the output shift.

Top module: `sysclk_ratio_gen`

## Requirements
- R1: The core divisor is selected by word bits 27:25. Codes 0,1,2,3,4 give 1,2,4,8,16 and codes 5,6,7 give 1. `core_en_o` pulses once every core-divisor selected ticks.
- R2: The bus divisor is selected by bits 22:20. Codes 0..7 give 1,2,4,5,6,8,16,32. `bus_en_o` pulses once every bus-divisor selected ticks.
- R3: Bits 19:18 select a peripheral divisor of 1,2,4,8 for codes 0..3. This divisor counts bus enables, so the period of `per_en_o` is bus divisor × peripheral divisor ticks. `per_en_o` is never high without `bus_en_o`.
- R4: Bit 23 chooses the source. When it is 0, `xtal_ce_i` is counted and `xtal_sel_o` is 1. When it is 1, `pll_ce_i` is counted and `xtal_sel_o` is 0. No enable is ever high outside a tick of the selected source.
- R5: A divisor of 1 makes its enable equal to the selected tick. The enable stays high when the tick is high every cycle.
- R6: For any divisor of 2 or more, each enable pulse lasts exactly one cycle while the source ticks every cycle.
- R7: A loaded word becomes active only on a selected tick where core, bus and peripheral enables are all high. The readbacks change on that clock edge and not before, and every enable period in progress completes at its old length.
- R8: A word loaded while an earlier one is still waiting replaces it. Only the most recent word is applied at the boundary.
- R9: `pll_num_o` = (bits 15:11 + 1) × (bits 10:5 + 1), `pll_den_o` = bits 4:0 + 1 and `pll_shift_o` = bits 17:16. All three are taken from the active word.
- R10: A synchronous active-low reset clears the active and shadow words to zero. This sets all divisors to 1, selects the crystal, discards any waiting word and gives a PLL readback of 1/1 with shift 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all ticks and strobes are in this domain |
| rst_n_i | input | 1 | Synchronous active-low reset |
| xtal_ce_i | input | 1 | Crystal source tick |
| pll_ce_i | input | 1 | PLL source tick |
| cfg_load_i | input | 1 | Captures `cfg_word_i` into the shadow register |
| cfg_word_i | input | 28 | New configuration word |
| core_en_o | output | 1 | Core clock enable strobe |
| bus_en_o | output | 1 | Bus clock enable strobe |
| per_en_o | output | 1 | Peripheral clock enable strobe |
| cfg_active_o | output | 28 | Configuration word currently in force |
| core_div_o | output | 6 | Active core divisor |
| bus_div_o | output | 6 | Active bus divisor |
| per_div_o | output | 6 | Active peripheral divisor (counted in bus enables) |
| xtal_sel_o | output | 1 | 1 while the crystal is the selected source |
| pll_num_o | output | 13 | PLL feedback product of the active word |
| pll_den_o | output | 6 | PLL input divisor of the active word |
| pll_shift_o | output | 2 | PLL output shift of the active word |

## Verification
The enables are combinational from the selected tick and the divider counters, so they are valid in the same cycle as the tick. The bench reads them at the falling edge and measures each period as the number of falling edges between two pulses.

A loaded word is captured at the next rising edge. It is then applied at the rising edge that ends the first common boundary, which can be as late as 256 ticks away, and all readbacks change on that same edge. The bench therefore either waits well beyond that worst case before checking the readbacks, or counts the interval from a known pulse and reads the old readback at the boundary cycle itself.

// File: rtl/sysclk_pkg.sv
// Package: sysclk_pkg
// Holds the configuration word layout and the three divisor lookup tables
// shared by the ratio generator and its checker.
// Assumes a 28-bit configuration word; the field positions are decoded by
// software-visible neighbours and are kept fixed.
package sysclk_pkg;

    localparam int CFG_BITS  = 28;
    localparam int CORE_LSB  = 25;  // 3-bit core ratio code
    localparam int NBYP_BIT  = 23;  // 1 = count PLL ticks
    localparam int BUS_LSB   = 20;  // 3-bit bus ratio code
    localparam int PER_LSB   = 18;  // 2-bit peripheral ratio code
    localparam int PS_LSB    = 16;  // 2-bit PLL output shift
    localparam int FB1_LSB   = 11;  // 5-bit first feedback term
    localparam int FB2_LSB   = 5;   // 6-bit second feedback term
    localparam int IPD_LSB   = 0;   // 5-bit input divider term

    // Core ratio table: powers of two up to 16, upper codes fall back to 1.
    function automatic int unsigned core_ratio(input logic [2:0] code);
        case (code)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd4:    return 16;
            default: return 1;
        endcase
    endfunction

    // Bus ratio table: non-uniform, includes 5 and 6.
    function automatic int unsigned bus_ratio(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 8;
            3'd6:    return 16;
            default: return 32;
        endcase
    endfunction

    // Peripheral ratio table, applied on top of the bus ratio.
    function automatic int unsigned per_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/sysclk_cfg_hold.sv
// Module: sysclk_cfg_hold
// Shadow and active configuration registers. A load captures the word
// into the shadow and marks it waiting; the waiting word moves to the
// active register on a cycle where apply_i is high. A later load while
// waiting overwrites the shadow.
// Assumes apply_i is a single-cycle boundary strobe from the dividers.
module sysclk_cfg_hold #(
    parameter int CFG_W = 28
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [CFG_W-1:0] word_i,
    input  logic             apply_i,
    output logic [CFG_W-1:0] active_o
);

    logic [CFG_W-1:0] shadow_q;
    logic             waiting_q;

    // Capture loads, track the waiting flag and promote at the boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            shadow_q  <= '0;
            waiting_q <= 1'b0;
            active_o  <= '0;
        end else begin
            if (load_i) begin
                shadow_q <= word_i;
            end
            waiting_q <= load_i | (waiting_q & ~apply_i);
            if (waiting_q && apply_i) begin
                active_o <= shadow_q;
            end
        end
    end

endmodule

// File: rtl/sysclk_ratio_lut.sv
// Module: sysclk_ratio_lut
// Decodes the ratio code fields of the active word into divisor values
// and the source selection.
// Assumes DIV_W is wide enough for the largest table entry (32).
module sysclk_ratio_lut #(
    parameter int DIV_W = 6
) (
    input  logic [2:0]       core_code_i,
    input  logic [2:0]       bus_code_i,
    input  logic [1:0]       per_code_i,
    input  logic             nbyp_i,
    output logic [DIV_W-1:0] core_div_o,
    output logic [DIV_W-1:0] bus_div_o,
    output logic [DIV_W-1:0] per_div_o,
    output logic             xtal_sel_o
);

    import sysclk_pkg::*;

    // Table lookups for the three ratios and the source choice.
    always_comb begin
        core_div_o = DIV_W'(core_ratio(core_code_i));
        bus_div_o  = DIV_W'(bus_ratio(bus_code_i));
        per_div_o  = DIV_W'(per_ratio(per_code_i));
        xtal_sel_o = ~nbyp_i;
    end

endmodule

// File: rtl/sysclk_tick_div.sv
// Module: sysclk_tick_div
// Counts input ticks modulo div_i and raises a strobe on the tick that
// ends each period. A divisor of 1 passes every tick through.
// Assumes div_i only changes on a cycle where the counter wraps to zero,
// so the counter is always below the divisor.
module sysclk_tick_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             last_o,
    output logic             pulse_o
);

    logic [DIV_W-1:0] cnt_q;

    // Terminal count and the qualified strobe.
    always_comb begin
        last_o  = (cnt_q == (div_i - DIV_W'(1)));
        pulse_o = tick_i & last_o;
    end

    // Advance on each tick and wrap at the terminal count.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= last_o ? '0 : cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sysclk_pll_info.sv
// Module: sysclk_pll_info
// Forms the PLL multiplier readback from the active word: feedback
// product, input divisor and output shift. Pure readback, no timing role.
// Assumes NUM_W >= FB1_W + FB2_W + 2 so the product cannot overflow.
module sysclk_pll_info #(
    parameter int FB1_W = 5,
    parameter int FB2_W = 6,
    parameter int IPD_W = 5,
    parameter int PS_W  = 2,
    localparam int NUM_W = FB1_W + FB2_W + 2,
    localparam int DEN_W = IPD_W + 1
) (
    input  logic [FB1_W-1:0] fb1_i,
    input  logic [FB2_W-1:0] fb2_i,
    input  logic [IPD_W-1:0] ipd_i,
    input  logic [PS_W-1:0]  ps_i,
    output logic [NUM_W-1:0] num_o,
    output logic [DEN_W-1:0] den_o,
    output logic [PS_W-1:0]  shift_o
);

    // Offset-by-one terms and their product.
    always_comb begin
        num_o   = (NUM_W'(fb1_i) + NUM_W'(1)) * (NUM_W'(fb2_i) + NUM_W'(1));
        den_o   = DEN_W'(ipd_i) + DEN_W'(1);
        shift_o = ps_i;
    end

endmodule

// File: rtl/sysclk_ratio_gen.sv
// Module: sysclk_ratio_gen (top)
// Derives core, bus and peripheral enable strobes from the selected source
// tick. The peripheral divider counts bus strobes. A loaded word is applied
// only at a tick where all three dividers end their periods together.
// Assumes both tick inputs are already in the clk_i domain.
module sysclk_ratio_gen #(
    parameter int CFG_W = 28,
    parameter int DIV_W = 6,
    parameter int FB1_W = 5,
    parameter int FB2_W = 6,
    parameter int IPD_W = 5,
    parameter int PS_W  = 2,
    localparam int NUM_W = FB1_W + FB2_W + 2,
    localparam int DEN_W = IPD_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             xtal_ce_i,
    input  logic             pll_ce_i,
    input  logic             cfg_load_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    output logic             core_en_o,
    output logic             bus_en_o,
    output logic             per_en_o,
    output logic [CFG_W-1:0] cfg_active_o,
    output logic [DIV_W-1:0] core_div_o,
    output logic [DIV_W-1:0] bus_div_o,
    output logic [DIV_W-1:0] per_div_o,
    output logic             xtal_sel_o,
    output logic [NUM_W-1:0] pll_num_o,
    output logic [DEN_W-1:0] pll_den_o,
    output logic [PS_W-1:0]  pll_shift_o
);

    import sysclk_pkg::*;

    logic src_tick;
    logic core_last, bus_last, per_last;
    logic boundary;

    sysclk_cfg_hold #(.CFG_W(CFG_W)) u_hold (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .load_i   (cfg_load_i),
        .word_i   (cfg_word_i),
        .apply_i  (boundary),
        .active_o (cfg_active_o)
    );

    sysclk_ratio_lut #(.DIV_W(DIV_W)) u_lut (
        .core_code_i (cfg_active_o[CORE_LSB +: 3]),
        .bus_code_i  (cfg_active_o[BUS_LSB +: 3]),
        .per_code_i  (cfg_active_o[PER_LSB +: 2]),
        .nbyp_i      (cfg_active_o[NBYP_BIT]),
        .core_div_o  (core_div_o),
        .bus_div_o   (bus_div_o),
        .per_div_o   (per_div_o),
        .xtal_sel_o  (xtal_sel_o)
    );

    // Source select and the common-boundary strobe.
    always_comb begin
        src_tick = xtal_sel_o ? xtal_ce_i : pll_ce_i;
        boundary = src_tick & core_last & bus_last & per_last;
    end

    sysclk_tick_div #(.DIV_W(DIV_W)) u_core_div (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .tick_i  (src_tick),
        .div_i   (core_div_o),
        .last_o  (core_last),
        .pulse_o (core_en_o)
    );

    sysclk_tick_div #(.DIV_W(DIV_W)) u_bus_div (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .tick_i  (src_tick),
        .div_i   (bus_div_o),
        .last_o  (bus_last),
        .pulse_o (bus_en_o)
    );

    sysclk_tick_div #(.DIV_W(DIV_W)) u_per_div (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .tick_i  (bus_en_o),
        .div_i   (per_div_o),
        .last_o  (per_last),
        .pulse_o (per_en_o)
    );

    sysclk_pll_info #(
        .FB1_W(FB1_W), .FB2_W(FB2_W), .IPD_W(IPD_W), .PS_W(PS_W)
    ) u_pll (
        .fb1_i   (cfg_active_o[FB1_LSB +: FB1_W]),
        .fb2_i   (cfg_active_o[FB2_LSB +: FB2_W]),
        .ipd_i   (cfg_active_o[IPD_LSB +: IPD_W]),
        .ps_i    (cfg_active_o[PS_LSB +: PS_W]),
        .num_o   (pll_num_o),
        .den_o   (pll_den_o),
        .shift_o (pll_shift_o)
    );

endmodule

// File: rtl/sysclk_ratio_gen_chk.sv
// Module: sysclk_ratio_gen_chk
// Port-level properties of the ratio generator, bound to the top.
// Assumes the same default widths as the top module.
module sysclk_ratio_gen_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             xtal_ce_i,
    input logic             pll_ce_i,
    input logic             core_en_o,
    input logic             bus_en_o,
    input logic             per_en_o,
    input logic [DIV_W-1:0] core_div_o,
    input logic [DIV_W-1:0] bus_div_o,
    input logic [DIV_W-1:0] per_div_o,
    input logic             xtal_sel_o
);

    p_core_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $countones(core_div_o) == 1 && core_div_o <= DIV_W'(16));

    p_bus_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        core_div_o != '0 && bus_div_o != DIV_W'(3) && bus_div_o != DIV_W'(7) && bus_div_o != '0);

    p_per_in_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        per_en_o |-> bus_en_o);

    p_src_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (core_en_o || bus_en_o) |-> (xtal_sel_o ? xtal_ce_i : pll_ce_i));

    p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (core_en_o && core_div_o != DIV_W'(1)) |=> (!core_en_o || core_div_o == DIV_W'(1)));

    p_apply_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && (!$stable(core_div_o) || !$stable(bus_div_o) || !$stable(per_div_o)))
        |-> $past(core_en_o && bus_en_o && per_en_o));

    p_reset_state_r10: assert property (@(posedge clk_i)
        !rst_n_i |=> (core_div_o == DIV_W'(1) && bus_div_o == DIV_W'(1)
                      && per_div_o == DIV_W'(1) && xtal_sel_o));

endmodule

bind sysclk_ratio_gen sysclk_ratio_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .xtal_ce_i  (xtal_ce_i),
    .pll_ce_i   (pll_ce_i),
    .core_en_o  (core_en_o),
    .bus_en_o   (bus_en_o),
    .per_en_o   (per_en_o),
    .core_div_o (core_div_o),
    .bus_div_o  (bus_div_o),
    .per_div_o  (per_div_o),
    .xtal_sel_o (xtal_sel_o)
);

// File: tb/sysclk_ratio_gen_tb_top.sv
// Bench for sysclk_ratio_gen: a vector table of ratio codes walked by one
// loop, then directed tests for reset, source select, boundary timing,
// overwrite of a waiting word and PLL readback.
module sysclk_ratio_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int SETTLE = 300;

    // {core code, bus code, per code, exp core, exp bus, exp per}
    localparam logic [23:0] VEC [NVEC] = '{
        {3'd0, 3'd0, 2'd0, 6'd1,  6'd1,  4'd1},
        {3'd1, 3'd1, 2'd1, 6'd2,  6'd2,  4'd2},
        {3'd2, 3'd3, 2'd0, 6'd4,  6'd5,  4'd1},
        {3'd3, 3'd4, 2'd1, 6'd8,  6'd6,  4'd2},
        {3'd4, 3'd5, 2'd2, 6'd16, 6'd8,  4'd4},
        {3'd5, 3'd6, 2'd3, 6'd1,  6'd16, 4'd8},
        {3'd6, 3'd7, 2'd0, 6'd1,  6'd32, 4'd1},
        {3'd7, 3'd2, 2'd3, 6'd1,  6'd4,  4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_ce = 1'b1;
    logic        pll_ce = 1'b0;
    logic        pll_run = 1'b0;
    logic [1:0]  pll_ph = 2'd0;
    logic        cfg_load = 1'b0;
    logic [27:0] cfg_word = '0;
    logic        core_en, bus_en, per_en, xtal_sel;
    logic [27:0] cfg_active;
    logic [5:0]  core_div, bus_div, per_div, pll_den;
    logic [12:0] pll_num;
    logic [1:0]  pll_shift;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // PLL tick model: one tick every third cycle, changed at falling edges.
    always @(negedge clk) begin
        if (pll_run) begin
            pll_ph <= (pll_ph == 2'd2) ? 2'd0 : pll_ph + 2'd1;
            pll_ce <= (pll_ph == 2'd2);
        end else begin
            pll_ph <= 2'd0;
            pll_ce <= 1'b0;
        end
    end

    sysclk_ratio_gen dut_i (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .xtal_ce_i    (xtal_ce),
        .pll_ce_i     (pll_ce),
        .cfg_load_i   (cfg_load),
        .cfg_word_i   (cfg_word),
        .core_en_o    (core_en),
        .bus_en_o     (bus_en),
        .per_en_o     (per_en),
        .cfg_active_o (cfg_active),
        .core_div_o   (core_div),
        .bus_div_o    (bus_div),
        .per_div_o    (per_div),
        .xtal_sel_o   (xtal_sel),
        .pll_num_o    (pll_num),
        .pll_den_o    (pll_den),
        .pll_shift_o  (pll_shift)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [27:0] mkword(input int c, input int b, input int p,
                                           input int nb, input int f1, input int f2,
                                           input int ipd, input int ps);
        logic [27:0] w;
        w = '0;
        w[27:25] = 3'(c);
        w[23]    = 1'(nb);
        w[22:20] = 3'(b);
        w[19:18] = 2'(p);
        w[17:16] = 2'(ps);
        w[15:11] = 5'(f1);
        w[10:5]  = 6'(f2);
        w[4:0]   = 5'(ipd);
        return w;
    endfunction

    function automatic logic pick(input int w);
        return (w == 0) ? core_en : (w == 1) ? bus_en : per_en;
    endfunction

    task automatic load(input logic [27:0] w);
        @(negedge clk);
        cfg_word = w;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Period in cycles between two consecutive pulses of one enable.
    task automatic measure(input int w, output int n);
        int guard;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!pick(w) && guard < 2000);
        n = 0;
        do begin @(negedge clk); n++; end while (!pick(w) && n < 2000);
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " core div"}, int'(core_div), 1);
        chk({tag, " bus div"}, int'(bus_div), 1);
        chk({tag, " per div"}, int'(per_div), 1);
        chk({tag, " xtal sel"}, int'(xtal_sel), 1);
        chk({tag, " pll num"}, int'(pll_num), 1);
        chk({tag, " pll den"}, int'(pll_den), 1);
        chk({tag, " pll shift"}, int'(pll_shift), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int per, cc, bc, pc, ec, eb, ep;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R10 reset");

        // R5: divide-by-1 enables follow the crystal tick.
        xtal_ce = 1'b0;
        #1;
        chk("R5 enable low without tick", int'({core_en, bus_en, per_en}), 0);
        @(negedge clk);
        xtal_ce = 1'b1;
        #1;
        chk("R5 enable held with tick", int'({core_en, bus_en, per_en}), 7);

        // Table walk: R1, R2, R3 decode and periods.
        for (int i = 0; i < NVEC; i++) begin
            cc = int'(VEC[i][23:21]); bc = int'(VEC[i][20:18]); pc = int'(VEC[i][17:16]);
            ec = int'(VEC[i][15:10]); eb = int'(VEC[i][9:4]);   ep = int'(VEC[i][3:0]);
            load(mkword(cc, bc, pc, 0, 0, 0, 0, 0));
            idle(SETTLE);
            chk("R1 core div readback", int'(core_div), ec);
            chk("R2 bus div readback", int'(bus_div), eb);
            chk("R3 per div readback", int'(per_div), ep);
            measure(0, per); chk("R1 core period", per, ec);
            measure(1, per); chk("R2 bus period", per, eb);
            measure(2, per); chk("R3 per period", per, eb * ep);
        end

        // R7: a change waits for the common boundary; no short period.
        load(mkword(4, 0, 0, 0, 0, 0, 0, 0));
        idle(SETTLE);
        do @(negedge clk); while (!core_en);
        cfg_word = mkword(1, 0, 0, 0, 0, 0, 0, 0);
        cfg_load = 1'b1;
        per = 0;
        do begin @(negedge clk); cfg_load = 1'b0; per++; end while (!core_en);
        chk("R7 old period completes", per, 16);
        chk("R7 readback old at boundary", int'(core_div), 16);
        measure(0, per);
        chk("R7 new period after boundary", per, 2);
        chk("R6 new divisor readback", int'(core_div), 2);

        // R8: a second load while waiting replaces the first.
        load(mkword(4, 7, 3, 0, 0, 0, 0, 0));
        idle(SETTLE + 100);
        do @(negedge clk); while (!per_en);
        cfg_word = mkword(1, 0, 0, 0, 0, 0, 0, 0);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_word = mkword(2, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        cfg_load = 1'b0;
        idle(5);
        chk("R7 no early apply", int'(core_div), 16);
        idle(SETTLE);
        chk("R8 last word wins core", int'(core_div), 4);
        chk("R8 last word wins bus", int'(bus_div), 1);

        // R4: PLL source, tick every third cycle.
        pll_run = 1'b1;
        load(mkword(0, 0, 0, 1, 0, 0, 0, 0));
        idle(50);
        chk("R4 pll selected", int'(xtal_sel), 0);
        measure(0, per); chk("R4 core period on pll", per, 3);
        measure(2, per); chk("R4 per period on pll", per, 3);
        load(mkword(1, 0, 0, 1, 0, 0, 0, 0));
        idle(50);
        measure(0, per); chk("R4 core div2 on pll", per, 6);
        load(mkword(0, 0, 0, 0, 0, 0, 0, 0));
        idle(50);
        chk("R4 crystal reselected", int'(xtal_sel), 1);
        measure(0, per); chk("R5 core period on crystal", per, 1);
        pll_run = 1'b0;

        // R9: PLL multiplier readback.
        load(mkword(0, 0, 0, 0, 3, 9, 4, 2));
        idle(20);
        chk("R9 pll num", int'(pll_num), 40);
        chk("R9 pll den", int'(pll_den), 5);
        chk("R9 pll shift", int'(pll_shift), 2);
        load(mkword(0, 0, 0, 0, 31, 63, 31, 3));
        idle(20);
        chk("R9 pll num max", int'(pll_num), 2048);
        chk("R9 pll den max", int'(pll_den), 32);
        chk("R9 active word", int'(cfg_active), int'(mkword(0, 0, 0, 0, 31, 63, 31, 3)));

        // R10: mid-run reset discards a waiting word.
        load(mkword(4, 7, 3, 1, 1, 1, 1, 1));
        idle(20);
        load(mkword(2, 2, 2, 0, 0, 0, 0, 0));
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(SETTLE);
        check_reset_state("R10 mid-run reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule